// File: doc/BRIEF.md
# Recursive Frame Averager

This block reduces temporal noise in a pixel stream. For each incoming pixel it fetches the running average kept for the same position in the previous frame. It moves that average toward the new sample by a weight of one over the current frame count. It then writes the refreshed average back to the same location and sends a rounded copy of it downstream, for example into a 3x3 spatial filter.

The weight is set by a frame counter. The counter is 1 on the first frame after reset, a restart or a new limit, and it rises by one at each later start of frame until it reaches a programmable limit. Because of this, the first frame passes the input through unchanged. The following frames form a true cumulative mean, and once the limit is reached the block behaves as a steady exponential average.

The stored average carries extra fractional bits beyond the pixel width, so rounding error does not accumulate when the count is large. The previous-average memory sits outside the block. It has a read port with a fixed latency and a write port, and the block aligns its own pipeline to that latency.

Top module: `frameAverager`

## Requirements
- R1: While reset is held and right after it is released, `outValid`, `wrEn` and `rdEn` are low.
- R2: When the frame count is 1, the output pixel equals the input pixel, `wrData` equals the input shifted left by FRAC_W, no read is issued (`rdEn` low), and whatever `rdData` carries has no effect.
- R3: The count in use for a frame is set on its start-of-frame beat. It is 1 if a restart or limit write was seen since the previous start of frame (or since reset), otherwise the previous count plus one, held at the limit. All beats of a frame use that count, and `rdEn` is high on a valid beat exactly when the count is not 1.
- R4: For a count N above 1, with stored average P and input I, the new average is P + floor(((I<<FRAC_W) − P)·R + 2^(RECIP_W−1)) / 2^RECIP_W, where R = floor((2^RECIP_W + floor(N/2)) / N). This value is written on `wrData`.
- R5: `outPix` equals floor((newAverage + 2^(FRAC_W−1)) / 2^FRAC_W), and it saturates at the largest pixel value.
- R6: The output beat and the write-back appear exactly RD_LAT+1 cycles after the input beat. `rdData` is taken RD_LAT cycles after `rdEn`.
- R7: The read address of a beat is its pixel index in the frame: 0 on the start-of-frame beat, then one more per valid beat, wrapping at 2^ADDR_W. The write address of the same beat is that same index.
- R8: A limit write stores 0 as 1 and any value above NMAX as NMAX, and it makes the next frame start again at count 1.
- R9: A restart pulse in the middle of a frame leaves the rest of that frame on its current count. The next frame runs at count 1.
- R10: `outSof` is high only on the output of a start-of-frame beat. Cycles with `inValid` low issue no read, no write and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Pulse: next frame starts the count again at 1 |
| limitWe | input | 1 | Load strobe for the frame-count limit |
| limitIn | input | $clog2(NMAX+1) | New frame-count limit |
| inValid | input | 1 | Input pixel beat |
| inSof | input | 1 | Beat is the first pixel of a frame |
| inPix | input | PIX_W | Input pixel |
| rdEn | output | 1 | Previous-average read request |
| rdAddr | output | ADDR_W | Read address (pixel index) |
| rdData | input | PIX_W+FRAC_W | Previous average, RD_LAT cycles after request |
| wrEn | output | 1 | Write-back strobe |
| wrAddr | output | ADDR_W | Write-back address |
| wrData | output | PIX_W+FRAC_W | Updated average with fractional bits |
| outValid | output | 1 | Output pixel beat |
| outSof | output | 1 | Output beat is first of a frame |
| outPix | output | PIX_W | Rounded averaged pixel |

## Verification
The bench builds the block with ADDR_W=4, NMAX=8 and RD_LAT=2, so each frame has sixteen pixels and the address counter wraps on every frame. With these values, the whole climb of the count from 1 to the limit, its hold at the limit, and every reciprocal weight from 1 to 8 fit in a few dozen frames. Limit writes of 0 and 12 reach both clamp ends. A two-cycle read latency exercises the alignment of the delay line with the memory return. Full-scale and all-zero frames drive the difference term to its extremes and the output rounding to saturation.

// File: rtl/avgPkg.sv
package avgPkg;
  // Per-beat strobes handed from control to datapath
  typedef struct packed {
    logic beat;  // valid pixel this cycle
    logic sof;   // valid pixel that opens a frame
    logic copy;  // count is 1: pass input through, ignore memory
  } beatStrobe_t;
endpackage

// File: rtl/avgRecipRom.sv
module avgRecipRom #(
  parameter int NMAX    = 256,
  parameter int N_W     = 9,
  parameter int RECIP_W = 16
) (
  input  logic [N_W-1:0]   n,
  output logic [RECIP_W:0] recip
);
  localparam int IW    = (NMAX > 1) ? $clog2(NMAX) : 1;
  localparam int DEPTH = 1 << IW;

  logic [RECIP_W:0] tbl [DEPTH];
  logic [IW-1:0]    idx;

  // entry i holds round(2^RECIP_W / (i+1)); unused tail repeats the last weight
  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    localparam int DIV = (i < NMAX) ? i + 1 : NMAX;
    assign tbl[i] = (RECIP_W+1)'(((1 << RECIP_W) + DIV / 2) / DIV);
  end

  assign idx   = IW'(n - N_W'(1));
  assign recip = tbl[idx];
endmodule

// File: rtl/avgCtrl.sv
module avgCtrl import avgPkg::*; #(
  parameter int ADDR_W = 20,
  parameter int NMAX   = 256,
  parameter int N_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              limitWe,
  input  logic [N_W-1:0]    limitIn,
  input  logic              inValid,
  input  logic              inSof,
  output beatStrobe_t       stb,
  output logic [N_W-1:0]    beatN,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam logic [N_W-1:0] N_ONE = N_W'(1);
  localparam logic [N_W-1:0] N_TOP = N_W'(NMAX);

  logic [N_W-1:0]    limitReg;
  logic [N_W-1:0]    curN;
  logic [N_W-1:0]    nextN;
  logic              fresh;
  logic [ADDR_W-1:0] pixCnt;
  logic              sofBeat;

  assign sofBeat = inValid & inSof;

  always_comb begin
    if (fresh)                nextN = N_ONE;
    else if (curN < limitReg) nextN = curN + N_ONE;
    else                      nextN = limitReg;
  end

  assign beatN    = sofBeat ? nextN : curN;
  assign beatAddr = inSof ? '0 : pixCnt;

  always_comb begin
    stb.beat = inValid;
    stb.sof  = sofBeat;
    stb.copy = (beatN == N_ONE);
  end

  assign rdEn   = inValid & ~stb.copy;
  assign rdAddr = beatAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitReg <= N_TOP;
      curN     <= N_ONE;
      fresh    <= 1'b1;
      pixCnt   <= '0;
    end else begin
      if (limitWe) begin
        if (limitIn == '0)       limitReg <= N_ONE;
        else if (limitIn > N_TOP) limitReg <= N_TOP;
        else                     limitReg <= limitIn;
      end
      if (sofBeat) begin
        curN  <= nextN;
        fresh <= 1'b0;
      end
      if (restart || limitWe) fresh <= 1'b1;
      if (inValid) pixCnt <= beatAddr + 1'b1;
    end
  end
endmodule

// File: rtl/avgDatapath.sv
module avgDatapath import avgPkg::*; #(
  parameter int PIX_W   = 10,
  parameter int FRAC_W  = 4,
  parameter int ADDR_W  = 20,
  parameter int NMAX    = 256,
  parameter int N_W     = 9,
  parameter int RECIP_W = 16,
  parameter int RD_LAT  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  beatStrobe_t             stb,
  input  logic [N_W-1:0]          beatN,
  input  logic [ADDR_W-1:0]       beatAddr,
  input  logic [PIX_W-1:0]        inPix,
  input  logic [PIX_W+FRAC_W-1:0] rdData,
  output logic                    wrEn,
  output logic [ADDR_W-1:0]       wrAddr,
  output logic [PIX_W+FRAC_W-1:0] wrData,
  output logic                    outValid,
  output logic                    outSof,
  output logic [PIX_W-1:0]        outPix
);
  localparam int AVG_W = PIX_W + FRAC_W;
  localparam int RW    = RECIP_W + 1;
  localparam int DW    = AVG_W + 1;
  localparam int PW    = DW + RW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (RECIP_W - 1));

  // delay line matching the memory read latency
  beatStrobe_t       stbD  [1:RD_LAT];
  logic [PIX_W-1:0]  pixD  [1:RD_LAT];
  logic [N_W-1:0]    nD    [1:RD_LAT];
  logic [ADDR_W-1:0] addrD [1:RD_LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 1; s <= RD_LAT; s++) begin
        stbD[s]  <= '0;
        pixD[s]  <= '0;
        nD[s]    <= '0;
        addrD[s] <= '0;
      end
    end else begin
      stbD[1]  <= stb;
      pixD[1]  <= inPix;
      nD[1]    <= beatN;
      addrD[1] <= beatAddr;
      for (int s = 2; s <= RD_LAT; s++) begin
        stbD[s]  <= stbD[s-1];
        pixD[s]  <= pixD[s-1];
        nD[s]    <= nD[s-1];
        addrD[s] <= addrD[s-1];
      end
    end
  end

  beatStrobe_t       stbL;
  logic [RW-1:0]     recip;
  logic [AVG_W-1:0]  iExt;
  logic [AVG_W-1:0]  sumAvg;
  logic [AVG_W-1:0]  newAvg;
  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic [AVG_W:0]    outRnd;
  logic [PIX_W-1:0]  pixNext;

  assign stbL = stbD[RD_LAT];

  avgRecipRom #(.NMAX(NMAX), .N_W(N_W), .RECIP_W(RECIP_W)) uRom (
    .n     (nD[RD_LAT]),
    .recip (recip)
  );

  always_comb begin
    iExt    = {pixD[RD_LAT], FRAC_W'(0)};
    diff    = $signed({1'b0, iExt}) - $signed({1'b0, rdData});
    prod    = PW'(diff) * $signed(PW'({1'b0, recip}));
    rnd     = prod + HALF;
    sumAvg  = rdData + AVG_W'(rnd >>> RECIP_W);
    newAvg  = stbL.copy ? iExt : sumAvg;
    outRnd  = {1'b0, newAvg} + (AVG_W+1)'(1 << (FRAC_W - 1));
    pixNext = outRnd[AVG_W] ? '1 : outRnd[AVG_W-1:FRAC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outPix   <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      outValid <= stbL.beat;
      outSof   <= stbL.sof;
      outPix   <= pixNext;
      wrEn     <= stbL.beat;
      wrAddr   <= addrD[RD_LAT];
      wrData   <= newAvg;
    end
  end
endmodule

// File: rtl/frameAverager.sv
module frameAverager import avgPkg::*; #(
  parameter int PIX_W   = 10,
  parameter int FRAC_W  = 4,
  parameter int ADDR_W  = 20,
  parameter int NMAX    = 256,
  parameter int RECIP_W = 16,
  parameter int RD_LAT  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         restart,
  input  logic                         limitWe,
  input  logic [$clog2(NMAX+1)-1:0]    limitIn,
  input  logic                         inValid,
  input  logic                         inSof,
  input  logic [PIX_W-1:0]             inPix,
  output logic                         rdEn,
  output logic [ADDR_W-1:0]            rdAddr,
  input  logic [PIX_W+FRAC_W-1:0]      rdData,
  output logic                         wrEn,
  output logic [ADDR_W-1:0]            wrAddr,
  output logic [PIX_W+FRAC_W-1:0]      wrData,
  output logic                         outValid,
  output logic                         outSof,
  output logic [PIX_W-1:0]             outPix
);
  localparam int N_W = $clog2(NMAX + 1);

  beatStrobe_t       stb;
  logic [N_W-1:0]    beatN;
  logic [ADDR_W-1:0] beatAddr;

  avgCtrl #(.ADDR_W(ADDR_W), .NMAX(NMAX), .N_W(N_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (restart),
    .limitWe  (limitWe),
    .limitIn  (limitIn),
    .inValid  (inValid),
    .inSof    (inSof),
    .stb      (stb),
    .beatN    (beatN),
    .beatAddr (beatAddr),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr)
  );

  avgDatapath #(
    .PIX_W(PIX_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .NMAX(NMAX),
    .N_W(N_W), .RECIP_W(RECIP_W), .RD_LAT(RD_LAT)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .beatN    (beatN),
    .beatAddr (beatAddr),
    .inPix    (inPix),
    .rdData   (rdData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .outValid (outValid),
    .outSof   (outSof),
    .outPix   (outPix)
  );
endmodule

// File: rtl/avgChecker.sv
module avgChecker #(
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inSof,
  input logic              restart,
  input logic              limitWe,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              outValid,
  input logic              outSof
);
  logic [RD_LAT:0]   vPipe;
  logic [RD_LAT:0]   sPipe;
  logic [ADDR_W-1:0] aPipe [RD_LAT+1];
  logic [ADDR_W-1:0] idxCnt;
  logic [ADDR_W-1:0] curIdx;
  logic              pend;

  assign curIdx = inSof ? '0 : idxCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe  <= '0;
      sPipe  <= '0;
      idxCnt <= '0;
      pend   <= 1'b1;
      for (int k = 0; k <= RD_LAT; k++) aPipe[k] <= '0;
    end else begin
      vPipe    <= {vPipe[RD_LAT-1:0], inValid};
      sPipe    <= {sPipe[RD_LAT-1:0], inValid & inSof};
      aPipe[0] <= curIdx;
      for (int k = 1; k <= RD_LAT; k++) aPipe[k] <= aPipe[k-1];
      if (inValid) idxCnt <= curIdx + 1'b1;
      if (inValid && inSof) pend <= 1'b0;
      if (restart || limitWe) pend <= 1'b1;
    end
  end

  a_r6_out_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vPipe[RD_LAT]);

  a_r10_sof_marker: assert property (@(posedge clk) disable iff (!rstN)
    outSof == sPipe[RD_LAT]);

  a_r7_wr_addr: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr == aPipe[RD_LAT]);

  a_r2_no_read_first: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && pend) |-> !rdEn);

  a_r10_idle_no_read: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !rdEn);
endmodule

bind frameAverager avgChecker #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) uAvgChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inSof    (inSof),
  .restart  (restart),
  .limitWe  (limitWe),
  .rdEn     (rdEn),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .outValid (outValid),
  .outSof   (outSof)
);

// File: tb/tb_frameAverager.sv
module tb_frameAverager;
  localparam int PIX_W   = 10;
  localparam int FRAC_W  = 4;
  localparam int ADDR_W  = 4;
  localparam int NMAX    = 8;
  localparam int RECIP_W = 16;
  localparam int RD_LAT  = 2;
  localparam int N_W     = $clog2(NMAX + 1);
  localparam int AVG_W   = PIX_W + FRAC_W;
  localparam int FRAME   = 1 << ADDR_W;
  localparam int QD      = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restart = 1'b0, limitWe = 1'b0, inValid = 1'b0, inSof = 1'b0;
  logic [N_W-1:0]    limitIn = '0;
  logic [PIX_W-1:0]  inPix = '0;
  logic              rdEn, wrEn, outValid, outSof;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [AVG_W-1:0]  rdData, wrData;
  logic [PIX_W-1:0]  outPix;

  always #2 clk = ~clk;

  frameAverager #(
    .PIX_W(PIX_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .NMAX(NMAX),
    .RECIP_W(RECIP_W), .RD_LAT(RD_LAT)
  ) dut (
    .clk(clk), .rstN(rstN), .restart(restart), .limitWe(limitWe), .limitIn(limitIn),
    .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outSof(outSof), .outPix(outPix)
  );

  // frame store with RD_LAT cycles of read latency; junk when no read
  logic [AVG_W-1:0] mem    [FRAME];
  logic [AVG_W-1:0] rdPipe [RD_LAT];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < FRAME; k++) mem[k] <= AVG_W'(k * 811 + 77);
    end else if (wrEn) mem[wrAddr] <= wrData;
    rdPipe[0] <= rdEn ? mem[rdAddr] : AVG_W'(14'h2A5A);
    for (int k = 1; k < RD_LAT; k++) rdPipe[k] <= rdPipe[k-1];
  end
  assign rdData = rdPipe[RD_LAT-1];

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state
  int  refP [FRAME];
  int  nModel = 1, limitModel = NMAX, idxModel = 0;
  bit  freshModel = 1'b1;

  int expPix [QD], expWr [QD], expAddr [QD], expSof [QD], expCyc [QD];
  int qHead = 0, qTail = 0;

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qHead == qTail) check("R10 unexpected output beat", 1, 0);
      else begin
        check("R5 outPix", longint'(outPix), longint'(expPix[qHead]));
        check("R4 wrData", longint'(wrData), longint'(expWr[qHead]));
        check("R7 wrAddr", longint'(wrAddr), longint'(expAddr[qHead]));
        check("R10 outSof", longint'(outSof), longint'(expSof[qHead]));
        check("R6 output cycle", longint'(cyc), longint'(expCyc[qHead]));
        check("R6 wrEn with output", longint'(wrEn), 1);
        qHead++;
      end
    end
  end

  task automatic beat(int pix, bit sof);
    int idx, newP, o, recipV;
    longint diff, delta;
    inValid = 1'b1;
    inSof   = sof;
    inPix   = PIX_W'(pix);
    if (sof) begin
      nModel     = freshModel ? 1 : ((nModel < limitModel) ? nModel + 1 : limitModel);
      freshModel = 1'b0;
      idxModel   = 0;
    end
    idx = idxModel;
    if (nModel == 1) newP = pix * 16;
    else begin
      recipV = ((1 << RECIP_W) + nModel / 2) / nModel;
      diff   = longint'(pix * 16 - refP[idx]);
      delta  = (diff * recipV + 32768) >>> RECIP_W;
      newP   = refP[idx] + int'(delta);
    end
    refP[idx] = newP;
    o = (newP + 8) >> FRAC_W;
    if (o > 1023) o = 1023;
    expPix[qTail]  = o;
    expWr[qTail]   = newP;
    expAddr[qTail] = idx;
    expSof[qTail]  = sof ? 1 : 0;
    expCyc[qTail]  = cyc + RD_LAT + 1;
    qTail++;
    @(negedge clk);
    // R3: a read is requested exactly when the count is above one (R2 otherwise)
    check("R3 rdEn vs count", longint'(rdEn), (nModel != 1) ? 1 : 0);
    if (nModel != 1) check("R7 rdAddr", longint'(rdAddr), longint'(idx));
    @(posedge clk); #1;
    inValid = 1'b0;
    inSof   = 1'b0;
    idxModel = (idx + 1) % FRAME;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      check("R10 idle no read", longint'(rdEn), 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic pulseRestart();
    restart = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
    freshModel = 1'b1;
  endtask

  task automatic setLimit(int v);
    limitWe = 1'b1;
    limitIn = N_W'(v);
    @(posedge clk); #1;
    limitWe = 1'b0;
    limitModel = (v == 0) ? 1 : ((v > NMAX) ? NMAX : v);
    freshModel = 1'b1;
  endtask

  function automatic int patPix(int f, int i, int pat);
    case (pat)
      1: return 1023;
      2: return 0;
      3: return (f % 2 == 0) ? 1023 : 0;
      default: return (f * 173 + i * 59 + i * i * 7) % 1024;
    endcase
  endfunction

  task automatic runFrame(int f, int pat, bit gaps, int restartAt);
    for (int i = 0; i < FRAME; i++) begin
      if (i == restartAt) pulseRestart();
      beat(patPix(f, i, pat), i == 0);
      if (gaps && (i % 5 == 2)) idle(1);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outValid in reset", longint'(outValid), 0);
    check("R1 wrEn in reset", longint'(wrEn), 0);
    check("R1 rdEn in reset", longint'(rdEn), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", longint'(outValid), 0);
    check("R1 wrEn after reset", longint'(wrEn), 0);
    @(posedge clk); #1;
    idle(2);

    // R3/R4: count climbs to 5 and holds, with and without gaps
    setLimit(5);
    for (int f = 0; f < 8; f++) runFrame(f, 0, f % 2 == 1, -1);
    // R9: restart in mid frame keeps the count for the rest of the frame
    runFrame(8, 0, 1'b0, 6);
    for (int f = 9; f < 12; f++) runFrame(f, 0, 1'b0, -1);
    // R8: zero limit clamps to 1, every frame is a copy (R2)
    setLimit(0);
    for (int f = 12; f < 14; f++) runFrame(f, 0, 1'b1, -1);
    // R8: oversize limit clamps to NMAX; extremes exercise R5
    setLimit(12);
    for (int f = 14; f < 18; f++) runFrame(f, 0, 1'b0, -1);
    for (int f = 18; f < 21; f++) runFrame(f, 1, 1'b0, -1);
    for (int f = 21; f < 24; f++) runFrame(f, 2, 1'b1, -1);
    for (int f = 24; f < 28; f++) runFrame(f, 3, 1'b0, -1);

    idle(RD_LAT + 4);
    check("R6 all beats produced output", longint'(qHead), longint'(qTail));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule